// File: doc/BRIEF.md
# Translation look-aside buffer with wired entries

This block is a small, fully associative translation buffer for a paged memory system. A requester presents a virtual address split into a page number (high bits) and a byte offset (low bits). The buffer compares the page number against every stored entry at once. On a hit it returns the stored frame number with the offset appended unchanged. On a miss it raises a page-table read toward a memory-side walker, waits for the answer, returns the translation and records the new page/frame pair.

Any valid entry can be pinned ("wired") through a side control. Pinned entries survive a flush and are never evicted. Eviction walks round-robin over the entries that are not pinned, and free slots are always used before anything is evicted. The walker's answer carries a present bit. An answer without it produces an access fault and leaves the buffer unchanged.

At most one miss is in flight. While a miss is in flight the request side is stalled through its ready signal.

Top module: `tlb_wired`

## Requirements
- R1: A successful response carries `rsp_paddr = {frame, offset}`, where offset is `req_vaddr[OFF_W-1:0]` of the accepted request, passed through unchanged.
- R2: A request accepted (`req_valid && req_ready`) whose page number matches a valid entry gives `rsp_valid=1`, `rsp_fault=0` in the very next cycle, and no walk is raised.
- R3: A request accepted on a miss raises `walk_req_valid` in the next cycle, with `walk_req_vpn` equal to the page number. Both stay unchanged until `walk_rsp_valid` is seen.
- R4: When the walk returns with `walk_rsp_present=1`, `rsp_valid` rises in the next cycle with `{walk_rsp_pfn, offset}`. The pair is then stored, so a later lookup of the same page hits.
- R5: A refill goes into the lowest-numbered invalid entry if there is one. Otherwise it evicts the first non-wired entry at or after a rotating pointer, and the pointer moves to the entry after the victim. Filling a free entry leaves the pointer where it is.
- R6: A walk answer with `walk_rsp_present=0` gives `rsp_fault=1` with `rsp_paddr=0`, and nothing is stored, so the same page misses again.
- R7: A one-cycle `flush` pulse invalidates every non-wired entry at the next clock edge.
- R8: Wired entries stay valid across a flush and are never chosen as the victim of a refill.
- R9: When every entry is wired, a successful walk still returns its translation but stores nothing.
- R10: With `pin_en=1`, the valid entry matching `pin_vpn` becomes wired if `pin_set=1` and non-wired if `pin_set=0`.
- R11: `req_ready` is low from the cycle after a miss is accepted until the cycle in which its response is presented, so only one miss is ever outstanding.
- R12: After reset, `req_ready=1`, `rsp_valid=0`, `walk_req_valid=0`, and all entries are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VPN_W+OFF_W | Virtual address: page number above the offset |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Access fault: page not present |
| walk_req_valid | output | 1 | Page-table read outstanding |
| walk_req_vpn | output | VPN_W | Page number to be read |
| walk_rsp_valid | input | 1 | Page-table answer strobe |
| walk_rsp_pfn | input | PFN_W | Frame number from the page table |
| walk_rsp_present | input | 1 | Page-table entry is valid |
| flush | input | 1 | Invalidate all non-wired entries |
| pin_en | input | 1 | Apply pin control this cycle |
| pin_vpn | input | VPN_W | Page number whose entry is pinned or released |
| pin_set | input | 1 | 1 pins the entry, 0 releases it |

## Verification
The checker examines the following in every cycle:
- hit response timing;
- the walk request being raised and then held steady;
- the ready stall during a walk;
- offset pass-through and the all-zero address on a fault;
- the fact that a fault never stores an entry;
- unique matching;
- the fact that a victim is never a wired entry;
- the exact valid-bit outcome of a flush.

The round-robin eviction order, the preference for free slots, refills with everything wired and pin release can only be shown by the bench's scripted sequences. In those sequences, which pages hit and which walk again reveal which entry was replaced.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_BUSY = 1'b1
   } walk_state_e;

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               lk_hit,
   output logic [ENTRIES-1:0] lk_hit_vec,
   output logic [PFN_W-1:0]   lk_pfn,
   input  logic               pin_en,
   input  logic [VPN_W-1:0]   pin_vpn,
   input  logic               pin_set,
   input  logic               flush,
   input  logic               ins_en,
   input  logic [IW-1:0]      ins_idx,
   input  logic [VPN_W-1:0]   ins_vpn,
   input  logic [PFN_W-1:0]   ins_pfn,
   output logic [ENTRIES-1:0] valid_vec,
   output logic [ENTRIES-1:0] wired_vec
);

   logic [PFN_W-1:0]   pfn_arr [ENTRIES];
   logic [ENTRIES-1:0] pin_hit;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic             w_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PFN_W-1:0] pfn_q;
      logic             sel_ins;

      assign sel_ins       = ins_en && (ins_idx == IW'(e));
      assign lk_hit_vec[e] = v_q && (vpn_q == lk_vpn);
      assign pin_hit[e]    = v_q && (vpn_q == pin_vpn);
      assign valid_vec[e]  = v_q;
      assign wired_vec[e]  = w_q;
      assign pfn_arr[e]    = pfn_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            w_q <= 1'b0;
         end else if (sel_ins) begin
            v_q <= 1'b1;
            w_q <= 1'b0;
         end else begin
            if (flush && !w_q) v_q <= 1'b0;
            if (pin_en && pin_hit[e]) w_q <= pin_set;
         end
      end

      always_ff @(posedge clk) begin
         if (sel_ins) begin
            vpn_q <= ins_vpn;
            pfn_q <= ins_pfn;
         end
      end
   end

   always_comb begin
      lk_pfn = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (lk_hit_vec[e]) lk_pfn = lk_pfn | pfn_arr[e];
      end
   end

   assign lk_hit = |lk_hit_vec;

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
   parameter int ENTRIES         = 8,
   parameter bit FILL_FREE_FIRST = 1'b1,
   localparam int IW             = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] wired_vec,
   input  logic               commit,
   output logic               vic_ok,
   output logic [IW-1:0]      vic_idx
);

   logic [IW-1:0] rr_ptr;
   logic          rr_ok;
   logic [IW-1:0] rr_idx;
   logic          use_rr;

   // rotating search: iterate downward so the nearest candidate wins
   always_comb begin
      rr_ok  = 1'b0;
      rr_idx = rr_ptr;
      for (int k = ENTRIES - 1; k >= 0; k--) begin
         if (!wired_vec[rr_ptr + IW'(k)]) begin
            rr_ok  = 1'b1;
            rr_idx = rr_ptr + IW'(k);
         end
      end
   end

   if (FILL_FREE_FIRST) begin : g_free_first
      logic          free_ok;
      logic [IW-1:0] free_idx;

      always_comb begin
         free_ok  = 1'b0;
         free_idx = '0;
         for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (!valid_vec[k]) begin
               free_ok  = 1'b1;
               free_idx = IW'(k);
            end
         end
      end

      assign vic_ok  = free_ok | rr_ok;
      assign vic_idx = free_ok ? free_idx : rr_idx;
      assign use_rr  = !free_ok;
   end else begin : g_rr_only
      assign vic_ok  = rr_ok;
      assign vic_idx = rr_idx;
      assign use_rr  = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rr_ptr <= '0;
      else if (commit && use_rr && rr_ok) rr_ptr <= rr_idx + IW'(1);
   end

endmodule

// File: rtl/tlb_walk_fsm.sv
module tlb_walk_fsm
   import tlb_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic busy
);

   walk_state_e st_q;
   walk_state_e st_d;

   always_comb begin
      st_d = st_q;
      case (st_q)
         WALK_IDLE: if (start) st_d = WALK_BUSY;
         WALK_BUSY: if (done)  st_d = WALK_IDLE;
         default:              st_d = WALK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= WALK_IDLE;
      else        st_q <= st_d;
   end

   assign busy = (st_q == WALK_BUSY);

endmodule

// File: rtl/tlb_wired.sv
module tlb_wired #(
   parameter int ENTRIES         = 8,
   parameter int VPN_W           = 20,
   parameter int OFF_W           = 12,
   parameter int PFN_W           = 20,
   parameter bit FILL_FREE_FIRST = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [VPN_W+OFF_W-1:0] req_vaddr,
   output logic                   rsp_valid,
   output logic [PFN_W+OFF_W-1:0] rsp_paddr,
   output logic                   rsp_fault,
   output logic                   walk_req_valid,
   output logic [VPN_W-1:0]       walk_req_vpn,
   input  logic                   walk_rsp_valid,
   input  logic [PFN_W-1:0]       walk_rsp_pfn,
   input  logic                   walk_rsp_present,
   input  logic                   flush,
   input  logic                   pin_en,
   input  logic [VPN_W-1:0]       pin_vpn,
   input  logic                   pin_set
);

   localparam int IW   = $clog2(ENTRIES);
   localparam int VA_W = VPN_W + OFF_W;
   localparam int PA_W = PFN_W + OFF_W;

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_entries
      $error("tlb_wired: ENTRIES must be a power of two and at least 2");
   end
   if (VPN_W < 1 || OFF_W < 1 || PFN_W < 1) begin : g_bad_width
      $error("tlb_wired: field widths must be positive");
   end

   logic [VPN_W-1:0]   lk_vpn;
   logic [OFF_W-1:0]   lk_off;
   logic               lk_hit;
   logic [ENTRIES-1:0] lk_hit_vec;
   logic [PFN_W-1:0]   lk_pfn;
   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] wired_vec;
   logic               vic_ok;
   logic [IW-1:0]      ins_idx;
   logic               ins_en;
   logic               walking;
   logic               accept;
   logic               hit_take;
   logic               miss_take;
   logic               walk_done;
   logic [VPN_W-1:0]   cur_vpn;
   logic [OFF_W-1:0]   cur_off;

   assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
   assign lk_off    = req_vaddr[OFF_W-1:0];
   assign req_ready = !walking;
   assign accept    = req_valid && req_ready;
   assign hit_take  = accept && lk_hit;
   assign miss_take = accept && !lk_hit;
   assign walk_done = walking && walk_rsp_valid;
   assign ins_en    = walk_done && walk_rsp_present && vic_ok;

   tlb_entry_array #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W)
   ) u_array (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_vpn     (lk_vpn),
      .lk_hit     (lk_hit),
      .lk_hit_vec (lk_hit_vec),
      .lk_pfn     (lk_pfn),
      .pin_en     (pin_en),
      .pin_vpn    (pin_vpn),
      .pin_set    (pin_set),
      .flush      (flush),
      .ins_en     (ins_en),
      .ins_idx    (ins_idx),
      .ins_vpn    (cur_vpn),
      .ins_pfn    (walk_rsp_pfn),
      .valid_vec  (valid_vec),
      .wired_vec  (wired_vec)
   );

   tlb_victim_sel #(
      .ENTRIES         (ENTRIES),
      .FILL_FREE_FIRST (FILL_FREE_FIRST)
   ) u_victim (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid_vec (valid_vec),
      .wired_vec (wired_vec),
      .commit    (ins_en),
      .vic_ok    (vic_ok),
      .vic_idx   (ins_idx)
   );

   tlb_walk_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .start (miss_take),
      .done  (walk_done),
      .busy  (walking)
   );

   always_ff @(posedge clk) begin
      if (accept) begin
         cur_vpn <= lk_vpn;
         cur_off <= lk_off;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= hit_take || walk_done;
         rsp_fault <= walk_done && !walk_rsp_present;
         if (hit_take)                          rsp_paddr <= {lk_pfn, lk_off};
         else if (walk_done && walk_rsp_present) rsp_paddr <= {walk_rsp_pfn, cur_off};
         else                                   rsp_paddr <= PA_W'(0);
      end
   end

   assign walk_req_valid = walking;
   assign walk_req_vpn   = cur_vpn;

endmodule

// File: rtl/tlb_wired_chk.sv
module tlb_wired_chk #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int OFF_W   = 12,
   parameter int PFN_W   = 20,
   localparam int IW     = $clog2(ENTRIES)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_valid,
   input logic                   req_ready,
   input logic [VPN_W+OFF_W-1:0] req_vaddr,
   input logic                   rsp_valid,
   input logic [PFN_W+OFF_W-1:0] rsp_paddr,
   input logic                   rsp_fault,
   input logic                   walk_req_valid,
   input logic [VPN_W-1:0]       walk_req_vpn,
   input logic                   walk_rsp_valid,
   input logic                   walk_rsp_present,
   input logic                   flush,
   input logic [ENTRIES-1:0]     lk_hit_vec,
   input logic [ENTRIES-1:0]     valid_vec,
   input logic [ENTRIES-1:0]     wired_vec,
   input logic                   ins_en,
   input logic [IW-1:0]          ins_idx
);

   logic [OFF_W-1:0] seen_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      seen_off <= '0;
      else if (req_valid && req_ready) seen_off <= req_vaddr[OFF_W-1:0];
   end

   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == seen_off); // R1

   AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && (|lk_hit_vec) |=> rsp_valid && !rsp_fault && !walk_req_valid); // R2

   AST_MISS_RAISES_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !(|lk_hit_vec) |=>
         walk_req_valid && walk_req_vpn == $past(req_vaddr[VPN_W+OFF_W-1:OFF_W])); // R3

   AST_WALK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid && !walk_rsp_valid |=> walk_req_valid && $stable(walk_req_vpn)); // R3

   AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_vec)); // R4

   AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_paddr == '0); // R6

   AST_FAULT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid && walk_rsp_valid && !walk_rsp_present |-> !ins_en); // R6

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush && !ins_en |=> (valid_vec & ~$past(wired_vec)) == '0); // R7

   AST_FLUSH_KEEPS_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec & $past(wired_vec)) == $past(wired_vec)); // R8

   AST_VICTIM_UNWIRED: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !wired_vec[ins_idx]); // R8

   AST_WIRED_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (wired_vec & ~valid_vec) == '0); // R8

   AST_ONE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req_valid |-> !req_ready); // R11

endmodule

bind tlb_wired tlb_wired_chk #(
   .ENTRIES (ENTRIES),
   .VPN_W   (VPN_W),
   .OFF_W   (OFF_W),
   .PFN_W   (PFN_W)
) u_chk (.*);

// File: tb/tlb_wired_test.sv
module tlb_wired_test;

   localparam int N     = 8;
   localparam int VPN_W = 20;
   localparam int OFF_W = 12;
   localparam int PFN_W = 20;

   typedef struct packed {
      logic [PFN_W+OFF_W-1:0] paddr;
      logic                   fault;
   } exp_t;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   req_valid;
   logic                   req_ready;
   logic [VPN_W+OFF_W-1:0] req_vaddr;
   logic                   rsp_valid;
   logic [PFN_W+OFF_W-1:0] rsp_paddr;
   logic                   rsp_fault;
   logic                   walk_req_valid;
   logic [VPN_W-1:0]       walk_req_vpn;
   logic                   walk_rsp_valid;
   logic [PFN_W-1:0]       walk_rsp_pfn;
   logic                   walk_rsp_present;
   logic                   flush;
   logic                   pin_en;
   logic [VPN_W-1:0]       pin_vpn;
   logic                   pin_set;

   int    total = 0;
   int    bad   = 0;
   int    cyc   = 0;
   exp_t  expq[$];
   string tagq[$];
   bit    walk_expected = 1'b0;
   exp_t  mon_e;
   string mon_t;

   always #5 clk = ~clk;

   tlb_wired #(.ENTRIES(N), .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
      .walk_req_valid(walk_req_valid), .walk_req_vpn(walk_req_vpn),
      .walk_rsp_valid(walk_rsp_valid), .walk_rsp_pfn(walk_rsp_pfn),
      .walk_rsp_present(walk_rsp_present),
      .flush(flush), .pin_en(pin_en), .pin_vpn(pin_vpn), .pin_set(pin_set)
   );

   function automatic logic [PFN_W-1:0] frame_of(input logic [VPN_W-1:0] v);
      return v ^ 20'hA5C30;
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on each response
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (expq.size() == 0) begin
            check("R2", "response with nothing pending", 1, 0);
         end else begin
            mon_e = expq.pop_front();
            mon_t = tagq.pop_front();
            check(mon_t, "rsp_paddr", 64'(rsp_paddr), 64'(mon_e.paddr));
            check(mon_t, "rsp_fault", 64'(rsp_fault), 64'(mon_e.fault));
         end
      end
      if (rst_n && walk_req_valid && !walk_expected)
         check("R2", "walk raised on a hit", 1, 0);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         total++;
         bad++;
         $display("FAIL R11 watchdog actual=%0d expected=<50000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // driver: one request, with a walk answer when a miss is expected
   task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                         input bit miss, input bit present, input string tag);
      exp_t e;
      e.fault = miss && !present;
      e.paddr = e.fault ? '0 : {frame_of(vpn), off};
      @(negedge clk);
      check("R11", "ready before request", 64'(req_ready), 1);
      req_valid = 1'b1;
      req_vaddr = {vpn, off};
      walk_expected = miss;
      expq.push_back(e);
      tagq.push_back(tag);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      if (!miss) begin
         check(tag, "hit answered next cycle", 64'(rsp_valid), 1);
      end else begin
         check("R3", "walk raised", 64'(walk_req_valid), 1);
         check("R3", "walk page", 64'(walk_req_vpn), 64'(vpn));
         check("R11", "ready low during walk", 64'(req_ready), 0);
         repeat (2) @(negedge clk);
         check("R3", "walk held", 64'(walk_req_valid), 1);
         walk_rsp_valid   = 1'b1;
         walk_rsp_pfn     = frame_of(vpn);
         walk_rsp_present = present;
         @(negedge clk);
         walk_rsp_valid = 1'b0;
         walk_expected  = 1'b0;
         check("R11", "ready back with response", 64'(req_ready), 1);
      end
      @(negedge clk);
      check(tag, "response delivered", 64'(expq.size()), 0);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic do_pin(input logic [VPN_W-1:0] vpn, input bit set);
      @(negedge clk);
      pin_en  = 1'b1;
      pin_vpn = vpn;
      pin_set = set;
      @(negedge clk);
      pin_en = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      req_valid = 1'b0;
      req_vaddr = '0;
      walk_rsp_valid = 1'b0;
      walk_rsp_pfn = '0;
      walk_rsp_present = 1'b0;
      flush = 1'b0;
      pin_en = 1'b0;
      pin_vpn = '0;
      pin_set = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      check("R12", "req_ready", 64'(req_ready), 1);
      check("R12", "rsp_valid", 64'(rsp_valid), 0);
      check("R12", "walk_req_valid", 64'(walk_req_valid), 0);

      lookup(20'h00010, 12'h123, 1, 1, "R4");   // R12: empty buffer misses
      lookup(20'h00010, 12'hFFF, 0, 1, "R2");
      lookup(20'h00010, 12'h000, 0, 1, "R1");
      lookup(20'h00020, 12'h456, 1, 0, "R6");
      lookup(20'h00020, 12'h456, 1, 1, "R6");   // not stored by the fault
      do_flush();
      lookup(20'h00010, 12'h321, 1, 1, "R7");   // lands in entry 0
      do_pin(20'h00010, 1'b1);
      do_flush();
      lookup(20'h00010, 12'h555, 0, 1, "R8");

      // R5: fill entries 1..7, then evict in rotating order
      for (int i = 0; i < 7; i++) lookup(20'h00030 + 20'(i), 12'(i * 3), 1, 1, "R5");
      lookup(20'h00040, 12'h040, 1, 1, "R5");   // evicts 0x30, pointer to 2
      lookup(20'h00030, 12'h030, 1, 1, "R5");   // evicts 0x31, pointer to 3
      lookup(20'h00032, 12'h032, 0, 1, "R5");
      lookup(20'h00040, 12'h041, 0, 1, "R5");
      lookup(20'h00031, 12'h031, 1, 1, "R5");   // evicts 0x32, pointer to 4
      for (int i = 0; i < 4; i++) lookup(20'h00050 + 20'(i), 12'h050, 1, 1, "R5");
      lookup(20'h00054, 12'h054, 1, 1, "R8");   // skips wired entry 0, evicts 0x40
      lookup(20'h00010, 12'h010, 0, 1, "R8");
      lookup(20'h00040, 12'h042, 1, 1, "R8");

      // R9: pin everything, then refill without storing
      do_pin(20'h00054, 1'b1);
      do_pin(20'h00040, 1'b1);
      do_pin(20'h00031, 1'b1);
      for (int i = 0; i < 4; i++) do_pin(20'h00050 + 20'(i), 1'b1);
      lookup(20'h00060, 12'hABC, 1, 1, "R9");
      lookup(20'h00060, 12'hABD, 1, 1, "R9");
      lookup(20'h00031, 12'h777, 0, 1, "R9");

      // R10: release one pin; the next flush removes it
      do_pin(20'h00031, 1'b0);
      do_flush();
      lookup(20'h00031, 12'h778, 1, 1, "R10");
      lookup(20'h00040, 12'h779, 0, 1, "R10");

      repeat (3) @(negedge clk);
      check("R2", "scoreboard empty", 64'(expq.size()), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule